// File: doc/BRIEF.md
# Two-Channel Datapath Self-Test Engine

This block checks the digital path of a two-channel sampled-data front end without needing any analog input. After a start request, the sample words from the converters are replaced by words from an internal pseudorandom generator. These words pass through the local registered datapath stage for a fixed number of sample cycles. Each word that leaves the stage is folded into a 16-bit compaction register. When the run is over, the engine stops by itself, sets a completion flag and places the signature in two byte-wide readback registers. Software compares that signature with a known-good value.

The generator is a 14-bit maximal-length shift register. Each run can either resume the sequence where the previous run left it, or reload the fixed seed first. The channel select decides which channel's datapath output is compacted. The normal data outputs are never gated, so the test words can be seen on the output buses while a run is in progress.

Top module: `dp_selftest_engine`

## Requirements
- R1: After reset, busy, done, sig_lo and sig_hi are all 0, and the generator holds the seed 14'h1ACE.
- R2: A start pulse seen at a rising edge while busy is low and chan_sel is non-zero begins a run. busy is high from the next cycle, and done is cleared at the same time.
- R3: A run injects exactly 512 generator words, one per cycle. busy stays high for 513 cycles in total, and done rises in the cycle after busy falls. done stays high until the next accepted start.
- R4: The generator steps as next = {s[12:0], s[13]^s[12]^s[11]^s[1]}, advancing once per injected word. Its state is never zero.
- R5: With seed_restart high at the accepted start, the first injected word is the seed. With seed_restart low, the first word is the generator state left after the previous run (the seed, if no run has happened since reset).
- R6: The datapath stage registers f(x) = x ^ (x >> 1) with one cycle of latency. Its input is adc_a / adc_b when idle. During a run, channel A receives the generator word g and channel B receives ~g (14 bits). out_a / out_b always show the stage output.
- R7: Compaction starts from 0 at each run. For each stage output word d, it applies m' = {m[14:0], m[15]^m[14]^m[12]^m[3]} ^ {2'b00, d}. chan_sel bit0 selects channel A and bit1 selects channel B. With 2'b01 or 2'b11, channel A is compacted. With 2'b10, channel B is compacted.
- R8: sig_lo = signature[7:0] and sig_hi = signature[15:8]. Both hold their value until the next run completes, including during that run.
- R9: A start that arrives while busy is high has no effect on the current run. A start with chan_sel = 2'b00 has no effect at all.
- R10: chan_sel and seed_restart are sampled only at the accepted start. Changes during a run do not alter the signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request pulse |
| chan_sel | input | 2 | Channel enable: bit0 = A, bit1 = B |
| seed_restart | input | 1 | 1: reload seed at start; 0: continue sequence |
| adc_a | input | 14 | Converter A sample |
| adc_b | input | 14 | Converter B sample |
| out_a | output | 14 | Channel A datapath output |
| out_b | output | 14 | Channel B datapath output |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| sig_lo | output | 8 | Signature low byte |
| sig_hi | output | 8 | Signature high byte |

## Verification
The hardest situation to reach from the ports is a start pulse that lands in the middle of a run, together with a change of channel select and seed mode. The bench drives this during an active run and then checks that the run still lasts 513 busy cycles and yields the signature of its original configuration. The continue mode needs a chain of runs, so the bench carries its own generator state from run to run. It then checks that a later restart run reproduces the very first signature.

// File: rtl/dp_selftest_engine.sv
module dp_selftest_engine #(
  parameter int          W       = 14,
  parameter int          RUN_LEN = 512,
  parameter logic [13:0] SEED    = 14'h1ACE
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   chan_sel,
  input  logic         seed_restart,
  input  logic [W-1:0] adc_a,
  input  logic [W-1:0] adc_b,
  output logic [W-1:0] out_a,
  output logic [W-1:0] out_b,
  output logic         busy,
  output logic         done,
  output logic [7:0]   sig_lo,
  output logic [7:0]   sig_hi
);
  localparam int          CW        = $clog2(RUN_LEN);
  localparam logic [CW-1:0] LAST    = CW'(RUN_LEN - 1);
  localparam logic [13:0] LFSR_TAPS = 14'h3802;
  localparam logic [15:0] MISR_TAPS = 16'hD008;

  logic          running, dp_vld, done_q;
  logic [CW-1:0] cnt;
  logic [W-1:0]  lfsr, dp_a, dp_b;
  logic [1:0]    sel_q;
  logic [15:0]   misr, sig_q;

  wire go     = start && !busy && (chan_sel != 2'b00);
  wire finish = dp_vld && !running;

  wire [W-1:0]  lfsr_next = {lfsr[W-2:0], ^(lfsr & LFSR_TAPS)};
  wire [W-1:0]  src_a     = running ? lfsr  : adc_a;
  wire [W-1:0]  src_b     = running ? ~lfsr : adc_b;
  wire [W-1:0]  fold      = sel_q[0] ? dp_a : dp_b;
  wire [15:0]   misr_next = {misr[14:0], ^(misr & MISR_TAPS)} ^ {{(16-W){1'b0}}, fold};

  assign busy   = running | dp_vld;
  assign done   = done_q;
  assign out_a  = dp_a;
  assign out_b  = dp_b;
  assign sig_lo = sig_q[7:0];
  assign sig_hi = sig_q[15:8];

  always_ff @(posedge clk) begin
    if (!rst_n)                   lfsr <= SEED;
    else if (go && seed_restart)  lfsr <= SEED;
    else if (running)             lfsr <= lfsr_next;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      dp_vld  <= 1'b0;
      cnt     <= '0;
      sel_q   <= 2'b01;
      done_q  <= 1'b0;
    end else begin
      dp_vld <= running;
      if (go) begin
        running <= 1'b1;
        cnt     <= '0;
        sel_q   <= chan_sel;
        done_q  <= 1'b0;
      end else if (running) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) running <= 1'b0;
      end
      if (finish) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    dp_a <= src_a ^ (src_a >> 1);
    dp_b <= src_b ^ (src_b >> 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      misr  <= '0;
      sig_q <= '0;
    end else begin
      if (go)          misr <= '0;
      else if (dp_vld) misr <= misr_next;
      if (finish)      sig_q <= misr_next;
    end
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R4
  AST_RUN_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    running && cnt == LAST |=> !running && dp_vld); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy); // R3
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    running && start && cnt != LAST |=> running && cnt == $past(cnt) + 1'b1); // R9
  AST_SIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(sig_q)); // R8
  AST_RESTART_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    go && seed_restart |=> lfsr == SEED); // R5
endmodule

// File: tb/dp_selftest_engine_tb.sv
`timescale 1ns/1ps
module dp_selftest_engine_tb;
  localparam logic [13:0] SEED = 14'h1ACE;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, seed_restart = 1'b0;
  logic [1:0]  chan_sel = 2'b00;
  logic [13:0] adc_a = '0, adc_b = '0, out_a, out_b;
  logic        busy, done;
  logic [7:0]  sig_lo, sig_hi;

  int checks = 0, errors = 0;
  logic [13:0] mdl_lfsr = SEED;
  logic [15:0] last_sig = 16'h0000;
  logic [15:0] first_a_sig = 16'h0000;

  always #5 clk = ~clk;

  dp_selftest_engine u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_sel(chan_sel),
    .seed_restart(seed_restart), .adc_a(adc_a), .adc_b(adc_b),
    .out_a(out_a), .out_b(out_b), .busy(busy), .done(done),
    .sig_lo(sig_lo), .sig_hi(sig_hi));

  function automatic logic [13:0] step(input logic [13:0] s);
    return {s[12:0], s[13] ^ s[12] ^ s[11] ^ s[1]};
  endfunction
  function automatic logic [13:0] fx(input logic [13:0] x);
    return x ^ (x >> 1);
  endfunction
  function automatic logic [15:0] mstep(input logic [15:0] m, input logic [13:0] d);
    return {m[14:0], m[15] ^ m[14] ^ m[12] ^ m[3]} ^ {2'b00, d};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_run(input logic [1:0] sel, input bit rst_gen, input bit poke,
                        output logic [15:0] got);
    logic [13:0] s, w0, nb;
    logic [15:0] m;
    int n;
    s  = rst_gen ? SEED : mdl_lfsr;
    w0 = s;
    m  = '0;
    for (int i = 0; i < 512; i++) begin
      nb = ~s;
      m  = mstep(m, sel[0] ? fx(s) : fx(nb));
      s  = step(s);
    end
    mdl_lfsr = s;
    @(negedge clk);
    chan_sel = sel; seed_restart = rst_gen; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(done == 1'b0, "R2 done cleared", done, 0);
    chk({sig_hi, sig_lo} == last_sig, "R8 sig held during run", {sig_hi, sig_lo}, last_sig);
    n = 1;
    @(negedge clk);
    nb = ~w0;
    chk(out_a == fx(w0), "R6 out_a live test word", out_a, fx(w0));
    chk(out_b == fx(nb), "R6 out_b live test word", out_b, fx(nb));
    if (busy) n++;
    if (poke) begin
      chan_sel = (sel == 2'b10) ? 2'b01 : 2'b10;
      seed_restart = ~rst_gen;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (busy) n++;
    end
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (busy) n++; else break;
    end
    chk(n == 513, "R3 busy cycle count", n, 513);
    chk(done == 1'b1, "R3 done after run", done, 1);
    chk({sig_hi, sig_lo} == m, "R7 signature", {sig_hi, sig_lo}, m);
    got = {sig_hi, sig_lo};
    last_sig = got;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] g, ga, gb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1 reset flags", {busy, done}, 0);
    chk({sig_hi, sig_lo} == 16'h0, "R1 reset signature", {sig_hi, sig_lo}, 0);

    // R6 idle passthrough
    adc_a = 14'h2A5C; adc_b = 14'h0F31;
    @(negedge clk); @(negedge clk);
    chk(out_a == fx(14'h2A5C), "R6 idle out_a", out_a, fx(14'h2A5C));
    chk(out_b == fx(14'h0F31), "R6 idle out_b", out_b, fx(14'h0F31));

    // R1/R4/R5 continue from reset starts at seed; channel A
    do_run(2'b01, 1'b0, 1'b0, ga);
    first_a_sig = ga;
    // R7 channel B alone, continuing
    do_run(2'b10, 1'b0, 1'b0, gb);
    // R7 both channels, continuing
    do_run(2'b11, 1'b0, 1'b0, g);
    // R5 restart reproduces first run
    do_run(2'b01, 1'b1, 1'b0, g);
    chk(g == first_a_sig, "R5 restart reproduces first signature", g, first_a_sig);
    // R5 continue back-to-back differs from restart
    do_run(2'b01, 1'b0, 1'b0, g);
    chk(g != first_a_sig, "R5 continue gives new signature", g, first_a_sig);
    // R7 both-channel restart equals channel A restart
    do_run(2'b11, 1'b1, 1'b0, g);
    chk(g == first_a_sig, "R7 both reports channel A", g, first_a_sig);
    // R7 channel B restart differs
    do_run(2'b10, 1'b1, 1'b0, g);
    chk(g != first_a_sig, "R7 channel B differs from A", g, first_a_sig);

    // R9 start with no channel ignored
    @(negedge clk);
    chan_sel = 2'b00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R9 empty select ignored busy", busy, 0);
    chk(done == 1, "R9 empty select keeps done", done, 1);
    chk({sig_hi, sig_lo} == last_sig, "R9 empty select keeps sig", {sig_hi, sig_lo}, last_sig);

    // R8 inputs changing while idle leave the signature
    adc_a = 14'h1111; adc_b = 14'h3333;
    repeat (5) @(negedge clk);
    chk({sig_hi, sig_lo} == last_sig, "R8 sig held idle", {sig_hi, sig_lo}, last_sig);

    // R9/R10 start, select and seed mode changed mid-run
    do_run(2'b01, 1'b0, 1'b1, g);
    do_run(2'b10, 1'b1, 1'b1, g);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule